// File: doc/BRIEF.md
# Eight-bit ALU with legacy decimal-mode behaviour

This block is the arithmetic and logic unit for an 8-bit accumulator datapath. It accepts one operation per handshake. Each operation carries two operand bytes (`a` and `m`), a carry input, a decimal-mode input and a 4-bit operation code. It returns one result byte and four flags: negative, overflow, zero and carry.

Binary addition and subtraction share a single adder. Subtraction adds the bit-inverted `m`. In decimal mode, an add applies nibble corrections that reproduce the odd results and odd flags of the legacy hardware. These apply to non-decimal digits too. A decimal subtract corrects only the result byte; its flags stay binary. Compare ops and the masked subtract reuse the same adder with the carry forced to 1 and decimal mode forced off.

The input side and the output side each use a valid/ready pair. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result appears on the next edge with `out_valid` set. Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new input is taken.

Top module: `alu8_quirk`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted input sets `out_valid` on the next rising edge, with its result and flags. Without a new acceptance, `out_valid` clears on the first edge where it is high and `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `res` and all flags hold their values and `out_valid` stays high. An input offered during that time is taken only after the stall ends.
- R3: After a synchronous reset (`rst` high on a rising edge), `out_valid` is 0 and `in_ready` is 1.
- R4: Op 0 (add) with `d_in`=0 computes a + m + c_in. C is the carry out of bit 7. V is 1 when a and m have the same sign bit and the result's sign bit differs from it. N is result bit 7, and Z is 1 for a zero result.
- R5: Op 1 (subtract) computes a + ~m + c_in through the same adder. C=1 means no borrow. With `d_in`=1, all four flags are still those of this binary sum.
- R6: Op 0 with `d_in`=1 forms a low digit from a[3:0]+m[3:0]+c_in. If that digit is 10 or more, it adds 6, keeps 4 bits and adds 0x10. This is added to the sum of the two high nibbles, and 0x60 is added when that total is at least 0xA0. The result is the low byte. Examples: 00+0F=15, 00+1F=25, 10+1F=35, 05+1F=2A, 0F+0A=1F, 0F+0B=10.
- R7: For op 0 with `d_in`=1: Z comes from the binary sum a+m+c_in. N is bit 7 of the total before the 0x60 correction. V uses the rule of R4, applied to that same uncorrected total. C is set when the corrected total exceeds 0xFF. Example: 80+80 gives 60 with Z=1, C=1, V=1.
- R8: Op 1 with `d_in`=1 returns the decimal difference with legacy corrections. Examples: 40-13 (carry 1) gives 27, and 00-01 (carry 1) gives 99.
- R9: Op 11 (compare) returns `a` unchanged as the result. N and Z come from a-m, C = (a >= m) and V = 0. `c_in` and `d_in` have no effect.
- R10: Ops 2, 3 and 4 (AND, OR, XOR of a with m) and ops 5 and 6 (m+1, m-1) set N and Z from the result, pass `c_in` to C and clear V.
- R11: Ops 7/8 shift m left/right with a 0 filling the vacated bit. Ops 9/10 rotate m left/right with `c_in` filling the vacated bit. C takes the bit shifted out, N and Z follow the result, and V=0.
- R12: Op 12 returns t = a&m with C = t[7]. Op 13 returns t>>1 with C = t[0]. For both, `c_in` is ignored and V=0.
- R13: Op 14 returns {c_in, t[7:1]} with t = a&m. C = t[7], and V is the R4 overflow rule applied to the 8-bit sum t+m.
- R14: Op 15 returns a - m. `c_in` and `d_in` are ignored. C = (a >= m), N and Z follow the result, and V is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op | input | 4 | Operation code (see requirements) |
| a | input | 8 | First operand (accumulator side) |
| m | input | 8 | Second operand (memory/immediate side) |
| c_in | input | 1 | Carry input |
| d_in | input | 1 | Decimal-mode select |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 8 | Result byte |
| n_out | output | 1 | Negative flag |
| v_out | output | 1 | Overflow flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |

## Verification
Every result and flag set is due one rising edge after the edge that accepts its input. The bench offers each input just after a falling edge and drops `in_valid` right after the accepting edge. It reads `res`, the flags and `out_valid` at the next falling edge, a full half period away from any register update. The stall scenario holds `out_ready` low across several edges and reads the frozen outputs at each falling edge. It then releases the stall and reads the queued operation's result one edge later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW = 8;
  localparam int NIB = DW / 2;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_AND    = 4'd2,
    OP_OR     = 4'd3,
    OP_XOR    = 4'd4,
    OP_INC    = 4'd5,
    OP_DEC    = 4'd6,
    OP_SHL    = 4'd7,
    OP_SHR    = 4'd8,
    OP_ROL    = 4'd9,
    OP_ROR    = 4'd10,
    OP_CMP    = 4'd11,
    OP_ANDC   = 4'd12,
    OP_ANDSHR = 4'd13,
    OP_ANDROR = 4'd14,
    OP_MSUB   = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter bit HAS_DECIMAL = 1'b1
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  input  logic          dec,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output flags_t        fl
);

  localparam int XW = DW + 2;

  logic [DW-1:0] m_eff;
  logic [DW:0]   bsum;
  flags_t        bfl;

  // one adder for both directions: subtraction sees the inverted operand
  assign m_eff = sub ? ~m : m;
  assign bsum  = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, cin};

  always_comb begin
    bfl.n = bsum[DW-1];
    bfl.z = (bsum[DW-1:0] == '0);
    bfl.c = bsum[DW];
    bfl.v = ~(a[DW-1] ^ m_eff[DW-1]) & (a[DW-1] ^ bsum[DW-1]);
  end

  generate
    if (HAS_DECIMAL) begin : g_bcd
      logic [NIB:0]  add_lo;
      logic [XW-1:0] add_hi;
      logic [XW-1:0] sub_lo;
      logic [XW-1:0] sub_hi;
      logic          dn;
      logic          dv;

      always_comb begin
        // decimal add: low digit fix-up, then high digit fix-up
        add_lo = {1'b0, a[NIB-1:0]} + {1'b0, m[NIB-1:0]} + {{NIB{1'b0}}, cin};
        if (add_lo >= (NIB+1)'(10)) add_lo = {1'b1, add_lo[NIB-1:0] + 4'd6};
        add_hi = {2'b0, a[DW-1:NIB], {NIB{1'b0}}} + {2'b0, m[DW-1:NIB], {NIB{1'b0}}}
               + {{(XW-NIB-1){1'b0}}, add_lo};
        // sign and overflow are taken before the high correction
        dn = add_hi[DW-1];
        dv = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ add_hi[DW-1]);
        if (add_hi >= XW'(16'h00A0)) add_hi = add_hi + XW'(16'h0060);

        // decimal subtract: signed fix-ups, flags stay binary
        sub_lo = {{(XW-NIB){1'b0}}, a[NIB-1:0]} - {{(XW-NIB){1'b0}}, m[NIB-1:0]}
               + {{(XW-1){1'b0}}, cin} - XW'(1);
        if (sub_lo[XW-1]) sub_lo = ((sub_lo - XW'(6)) & XW'(16'h000F)) - XW'(16'h0010);
        sub_hi = {2'b0, a[DW-1:NIB], {NIB{1'b0}}} - {2'b0, m[DW-1:NIB], {NIB{1'b0}}} + sub_lo;
        if (sub_hi[XW-1]) sub_hi = sub_hi - XW'(16'h0060);

        if (dec && !sub) begin
          sum  = add_hi[DW-1:0];
          fl.n = dn;
          fl.v = dv;
          fl.z = bfl.z;
          fl.c = |add_hi[XW-1:DW];
        end else if (dec) begin
          sum = sub_hi[DW-1:0];
          fl  = bfl;
        end else begin
          sum = bsum[DW-1:0];
          fl  = bfl;
        end
      end
    end else begin : g_bin
      assign sum = bsum[DW-1:0];
      assign fl  = bfl;
    end
  endgenerate

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  op_e           opc,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  output logic [DW-1:0] res,
  output flags_t        fl
);

  logic [DW-1:0] masked;
  logic [DW-1:0] msum;
  logic          cy;
  logic          ov;

  assign masked = a & m;
  assign msum   = masked + m;

  always_comb begin
    res = '0;
    cy  = cin;
    ov  = 1'b0;
    unique case (opc)
      OP_AND: res = a & m;
      OP_OR:  res = a | m;
      OP_XOR: res = a ^ m;
      OP_INC: res = m + 1'b1;
      OP_DEC: res = m - 1'b1;
      OP_SHL: begin res = {m[DW-2:0], 1'b0}; cy = m[DW-1]; end
      OP_SHR: begin res = {1'b0, m[DW-1:1]}; cy = m[0];    end
      OP_ROL: begin res = {m[DW-2:0], cin};  cy = m[DW-1]; end
      OP_ROR: begin res = {cin, m[DW-1:1]};  cy = m[0];    end
      OP_ANDC: begin
        res = masked;
        cy  = masked[DW-1];
      end
      OP_ANDSHR: begin
        res = {1'b0, masked[DW-1:1]};
        cy  = masked[0];
      end
      OP_ANDROR: begin
        res = {cin, masked[DW-1:1]};
        cy  = masked[DW-1];
        ov  = ~(masked[DW-1] ^ m[DW-1]) & (masked[DW-1] ^ msum[DW-1]);
      end
      default: ;
    endcase
    fl.n = res[DW-1];
    fl.z = (res == '0);
    fl.c = cy;
    fl.v = ov;
  end

endmodule

// File: rtl/alu8_quirk.sv
module alu8_quirk
  import alu8_pkg::*;
#(
  parameter bit HAS_DECIMAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          c_in,
  input  logic          d_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] res,
  output logic          n_out,
  output logic          v_out,
  output logic          z_out,
  output logic          c_out
);

  op_e           opc;
  logic          fire;
  logic          is_arith;
  logic          is_cmp;
  logic          is_msub;
  logic          add_sub;
  logic          add_cin;
  logic          add_dec;
  logic [DW-1:0] add_sum;
  flags_t        add_fl;
  logic [DW-1:0] bit_res;
  flags_t        bit_fl;
  logic [DW-1:0] nxt_res;
  flags_t        nxt_fl;
  flags_t        fl_q;

  assign opc      = op_e'(op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  assign is_arith = (opc == OP_ADD) || (opc == OP_SUB);
  assign is_cmp   = (opc == OP_CMP);
  assign is_msub  = (opc == OP_MSUB);
  assign add_sub  = (opc != OP_ADD);
  assign add_cin  = (is_cmp || is_msub) ? 1'b1 : c_in;
  assign add_dec  = is_arith ? d_in : 1'b0;

  alu8_addsub #(.HAS_DECIMAL(HAS_DECIMAL)) u_addsub (
    .a   (a),
    .m   (m),
    .cin (add_cin),
    .dec (add_dec),
    .sub (add_sub),
    .sum (add_sum),
    .fl  (add_fl)
  );

  alu8_bitops u_bitops (
    .opc (opc),
    .a   (a),
    .m   (m),
    .cin (c_in),
    .res (bit_res),
    .fl  (bit_fl)
  );

  always_comb begin
    if (is_arith) begin
      nxt_res = add_sum;
      nxt_fl  = add_fl;
    end else if (is_cmp) begin
      nxt_res = a;
      nxt_fl  = '{n: add_fl.n, v: 1'b0, z: add_fl.z, c: add_fl.c};
    end else if (is_msub) begin
      nxt_res = add_sum;
      nxt_fl  = '{n: add_fl.n, v: 1'b0, z: add_fl.z, c: add_fl.c};
    end else begin
      nxt_res = bit_res;
      nxt_fl  = bit_fl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      fl_q      <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        res       <= nxt_res;
        fl_q      <= nxt_fl;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign n_out = fl_q.n;
  assign v_out = fl_q.v;
  assign z_out = fl_q.z;
  assign c_out = fl_q.c;

  // R1: an accepted operation is presented on the next edge
  p_deliver_r1: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid)
    else $error("R1: accepted operation not delivered");

  // R2: stalled output is frozen
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(fl_q)))
    else $error("R2: output changed under back-pressure");

  // R4: zero flag agrees with the result for non-decimal, non-compare ops
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && !d_in && (opc != OP_CMP)) |=> (z_out == (res == '0)))
    else $error("R4: zero flag disagrees with result");

  // R9: compare leaves the operand as the result and never flags overflow
  p_cmp_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && (opc == OP_CMP)) |=> ((res == $past(a)) && !v_out))
    else $error("R9: compare altered the operand");

  // R10: logic and step ops pass the carry through
  p_carry_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && (opc inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC})) |=> (c_out == $past(c_in)))
    else $error("R10: carry not passed through");

  // R14: masked subtract never reports overflow
  p_msub_nov_r14: assert property (@(posedge clk) disable iff (rst)
    (fire && (opc == OP_MSUB)) |=> !v_out)
    else $error("R14: masked subtract set overflow");

endmodule

// File: tb/alu8_quirk_test.sv
`timescale 1ns/1ps
module alu8_quirk_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [3:0] op;
  logic [7:0] a;
  logic [7:0] m;
  logic       c_in;
  logic       d_in;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] res;
  logic       n_out;
  logic       v_out;
  logic       z_out;
  logic       c_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu8_quirk uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op),
    .a         (a),
    .m         (m),
    .c_in      (c_in),
    .d_in      (d_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res       (res),
    .n_out     (n_out),
    .v_out     (v_out),
    .z_out     (z_out),
    .c_out     (c_out)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h expected=%h", req, what, got, exp);
    end
  endtask

  // flags are compared as {n,v,z,c}
  task automatic run_op(input string req, input logic [3:0] o, input logic [7:0] av, input logic [7:0] mv,
                        input logic ci, input logic di, input logic [7:0] er, input logic [3:0] ef);
    @(negedge clk);
    op = o; a = av; m = mv; c_in = ci; d_in = di; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(req, "valid", {7'b0, out_valid}, 8'h01);
    check(req, "result", res, er);
    check(req, "flags", {4'b0, n_out, v_out, z_out, c_out}, {4'b0, ef});
  endtask

  task automatic t_reset;
    check("R3", "out_valid after reset", {7'b0, out_valid}, 8'h00);
    check("R3", "in_ready after reset", {7'b0, in_ready}, 8'h01);
  endtask

  task automatic t_bin_add;
    run_op("R4", 4'd0, 8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 4'b1100);
    run_op("R4", 4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0011);
    run_op("R4", 4'd0, 8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 4'b0000);
  endtask

  task automatic t_sub;
    run_op("R5", 4'd1, 8'h50, 8'hF0, 1'b1, 1'b0, 8'h60, 4'b0000);
    run_op("R5", 4'd1, 8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 4'b0101);
    run_op("R8", 4'd1, 8'h40, 8'h13, 1'b1, 1'b1, 8'h27, 4'b0001);
    run_op("R8", 4'd1, 8'h00, 8'h01, 1'b1, 1'b1, 8'h99, 4'b1000);
  endtask

  task automatic t_dec_add;
    run_op("R6", 4'd0, 8'h00, 8'h0F, 1'b0, 1'b1, 8'h15, 4'b0000);
    run_op("R6", 4'd0, 8'h00, 8'h1F, 1'b0, 1'b1, 8'h25, 4'b0000);
    run_op("R6", 4'd0, 8'h10, 8'h1F, 1'b0, 1'b1, 8'h35, 4'b0000);
    run_op("R6", 4'd0, 8'h05, 8'h1F, 1'b0, 1'b1, 8'h2A, 4'b0000);
    run_op("R6", 4'd0, 8'h0F, 8'h0A, 1'b0, 1'b1, 8'h1F, 4'b0000);
    run_op("R6", 4'd0, 8'h0F, 8'h0B, 1'b0, 1'b1, 8'h10, 4'b0000);
    run_op("R6", 4'd0, 8'h19, 8'h01, 1'b0, 1'b1, 8'h20, 4'b0000);
  endtask

  task automatic t_dec_flags;
    run_op("R7", 4'd0, 8'h80, 8'h80, 1'b0, 1'b1, 8'h60, 4'b0111);
    run_op("R7", 4'd0, 8'h79, 8'h00, 1'b1, 1'b1, 8'h80, 4'b1100);
    run_op("R7", 4'd0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 4'b1001);
    run_op("R7", 4'd0, 8'h58, 8'h46, 1'b1, 1'b1, 8'h05, 4'b1101);
  endtask

  task automatic t_cmp;
    run_op("R9", 4'd11, 8'h40, 8'h30, 1'b0, 1'b1, 8'h40, 4'b0001);
    run_op("R9", 4'd11, 8'h30, 8'h40, 1'b1, 1'b0, 8'h30, 4'b1000);
    run_op("R9", 4'd11, 8'h55, 8'h55, 1'b0, 1'b0, 8'h55, 4'b0011);
  endtask

  task automatic t_logic;
    run_op("R10", 4'd2, 8'hF0, 8'h3C, 1'b1, 1'b0, 8'h30, 4'b0001);
    run_op("R10", 4'd3, 8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 4'b1000);
    run_op("R10", 4'd4, 8'h5A, 8'h5A, 1'b1, 1'b0, 8'h00, 4'b0011);
    run_op("R10", 4'd5, 8'h12, 8'hFF, 1'b1, 1'b1, 8'h00, 4'b0011);
    run_op("R10", 4'd6, 8'h12, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b1000);
  endtask

  task automatic t_shift;
    run_op("R11", 4'd7,  8'h00, 8'h81, 1'b0, 1'b0, 8'h02, 4'b0001);
    run_op("R11", 4'd8,  8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0011);
    run_op("R11", 4'd9,  8'h00, 8'h80, 1'b1, 1'b0, 8'h01, 4'b0001);
    run_op("R11", 4'd10, 8'h00, 8'h01, 1'b1, 1'b0, 8'h80, 4'b1001);
    run_op("R11", 4'd10, 8'h00, 8'h02, 1'b0, 1'b0, 8'h01, 4'b0000);
  endtask

  task automatic t_and_combo;
    run_op("R12", 4'd12, 8'hF0, 8'h8F, 1'b0, 1'b0, 8'h80, 4'b1001);
    run_op("R12", 4'd12, 8'h0F, 8'h8F, 1'b1, 1'b0, 8'h0F, 4'b0000);
    run_op("R12", 4'd13, 8'hFF, 8'h03, 1'b0, 1'b0, 8'h01, 4'b0001);
    run_op("R12", 4'd13, 8'hFF, 8'h02, 1'b1, 1'b0, 8'h01, 4'b0000);
  endtask

  task automatic t_arr;
    run_op("R13", 4'd14, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 4'b1001);
    run_op("R13", 4'd14, 8'h40, 8'h40, 1'b0, 1'b0, 8'h20, 4'b0100);
    run_op("R13", 4'd14, 8'h80, 8'h80, 1'b1, 1'b0, 8'hC0, 4'b1101);
  endtask

  task automatic t_msub;
    run_op("R14", 4'd15, 8'h10, 8'h05, 1'b0, 1'b0, 8'h0B, 4'b0001);
    run_op("R14", 4'd15, 8'h05, 8'h10, 1'b1, 1'b1, 8'hF5, 4'b1000);
    run_op("R14", 4'd15, 8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b0001);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    op = 4'd0; a = 8'h01; m = 8'h01; c_in = 1'b0; d_in = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    #1;
    a = 8'h03; m = 8'h04;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2", "valid held", {7'b0, out_valid}, 8'h01);
      check("R2", "result held", res, 8'h02);
      check("R1", "ready low in stall", {7'b0, in_ready}, 8'h00);
    end
    out_ready = 1'b1;
    #0.5;
    check("R1", "ready on drain", {7'b0, in_ready}, 8'h01);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R2", "queued result", res, 8'h07);
    check("R2", "queued valid", {7'b0, out_valid}, 8'h01);
    @(negedge clk);
    check("R1", "valid cleared after drain", {7'b0, out_valid}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    op = 4'd0; a = 8'h00; m = 8'h00; c_in = 1'b0; d_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bin_add();
    t_sub();
    t_dec_add();
    t_dec_flags();
    t_cmp();
    t_logic();
    t_shift();
    t_and_combo();
    t_arr();
    t_msub();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule